// File: doc/BRIEF.md
# Packed Integer-to-Double Conversion Unit

This execution unit takes a 128-bit operand and converts the two signed 32-bit integers in its low 64 bits into two IEEE-754 binary64 values. It packs them into a 128-bit result. Every 32-bit integer has an exact binary64 form, so the unit needs no rounding and never reports a floating-point exception.

At issue the unit also checks the architectural gating conditions: an emulation control bit, an OS support bit for the extended save state, a feature-present flag and a task-switched bit. When the operation must not run, the unit returns a fault code in place of a result.

Operations enter through a valid/ready port and leave through a valid-only result port after a fixed four-stage pipeline. The unit accepts one operation per clock.

Top module: `int2dbl_unit`

## Requirements
- R1: When the operation completes without a fault, `outResult[63:0]` is the exact binary64 encoding of `inOperand[31:0]` (sign in bit 63, 11-bit biased exponent in bits 62:52 with bias 1023, fraction in bits 51:0).
- R2: When the operation completes without a fault, `outResult[127:64]` is the exact binary64 encoding of `inOperand[63:32]`, in the same field layout.
- R3: Each lane is read as a two's-complement signed 32-bit value. Negative inputs, including -2147483648, give sign 1 and the magnitude of the input.
- R4: A lane holding integer zero yields +0.0, which is all 64 bits zero.
- R5: `inOperand[127:64]` has no effect on any output.
- R6: If `inEmulate` is 1, or `inOsSave` is 0, or `inFeatureOn` is 0, the operation completes with `outFault` = 2'b01 (invalid opcode).
- R7: If none of the R6 conditions holds and `inTaskSwitched` is 1, the operation completes with `outFault` = 2'b10 (device not available). Otherwise `outFault` = 2'b00.
- R8: When an R6 condition and `inTaskSwitched` both hold, the code is 2'b01.
- R9: A faulting operation still raises `outValid`, but `outResult` is all zero. `outFault` is nonzero only while `outValid` is 1.
- R10: An operation accepted on a rising edge (`inValid` and `inReady` both 1) appears at the outputs right after the fourth rising edge, counting the accepting edge as the first. `inReady` stays 1 from the first edge after reset, so back-to-back operations are accepted every cycle. In every other cycle `outValid` is 0.
- R11: While `rstN` is low, `outValid`, `outFault`, `outResult` and `inReady` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered this cycle |
| inReady | output | 1 | Unit can accept an operation |
| inOperand | input | 128 | Source operand; only bits 63:0 are used |
| inEmulate | input | 1 | Emulation control bit (1 blocks the operation) |
| inOsSave | input | 1 | OS support for extended state save (0 blocks) |
| inFeatureOn | input | 1 | Feature-present flag (0 blocks) |
| inTaskSwitched | input | 1 | Task-switched bit (1 gives device-not-available) |
| outValid | output | 1 | Result or fault is present |
| outFault | output | 2 | 00 none, 01 invalid opcode, 10 device not available |
| outResult | output | 128 | Two packed binary64 values, or zero on a fault |

## Verification
Two functions can land on the same operation: both fault causes can be present at issue, and the fault gate then has to choose one code. The bench sweeps all sixteen combinations of the four control inputs back to back, so operations with two causes enter the pipeline directly next to clean conversions and single-cause faults. Each completed operation is judged against a code and result worked out in the bench, so a wrong priority or a fault leaking into a neighbour's data shows up in the code or the payload. The conversions are compared with the bench's own integer-to-real conversion, over lane values that walk every bit position and over random operands.

// File: rtl/int2dbl_pkg.sv
`timescale 1ns/1ps
package int2dbl_pkg;
  localparam int DBL_W    = 64;
  localparam int EXP_W    = 11;
  localparam int FRAC_W   = 52;
  localparam int EXP_BIAS = 1023;
  localparam int PIPE_STG = 3;  // register stages ahead of the output register

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_BAD_OP = 2'b01,
    FLT_NO_DEV = 2'b10
  } fault_e;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
    logic s3Load;
    logic outLoad;
    logic outZero;
  } dpStrobe_t;
endpackage

// File: rtl/int2dbl_lane.sv
`timescale 1ns/1ps
module int2dbl_lane
  import int2dbl_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ld1,
  input  logic             ld2,
  input  logic             ld3,
  input  logic [INT_W-1:0] src,
  output logic [DBL_W-1:0] packedVal
);
  localparam int POS_W = $clog2(INT_W);
  localparam int PAD_W = FRAC_W - (INT_W - 1);

  function automatic logic [POS_W-1:0] leadPos(input logic [INT_W-1:0] v);
    leadPos = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (v[i]) leadPos = POS_W'(i);
    end
  endfunction

  // stage 1: sign and magnitude
  logic             sign1, zero1;
  logic [INT_W-1:0] mag1;
  // stage 2: leading-one position
  logic             sign2, zero2;
  logic [INT_W-1:0] mag2;
  logic [POS_W-1:0] pos2;
  // stage 3: exponent and fraction
  logic              sign3, zero3;
  logic [EXP_W-1:0]  exp3;
  logic [FRAC_W-1:0] frac3;

  logic [INT_W-1:0] magNext;
  logic [INT_W-1:0] normVal;
  logic [POS_W-1:0] shiftAmt;

  always_comb begin
    magNext  = src[INT_W-1] ? (~src + INT_W'(1)) : src;
    shiftAmt = POS_W'(INT_W - 1) - pos2;
    normVal  = mag2 << shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sign1 <= 1'b0; zero1 <= 1'b1; mag1 <= '0;
      sign2 <= 1'b0; zero2 <= 1'b1; mag2 <= '0; pos2 <= '0;
      sign3 <= 1'b0; zero3 <= 1'b1; exp3 <= '0; frac3 <= '0;
    end else begin
      if (ld1) begin
        sign1 <= src[INT_W-1];
        zero1 <= (src == '0);
        mag1  <= magNext;
      end
      if (ld2) begin
        sign2 <= sign1;
        zero2 <= zero1;
        mag2  <= mag1;
        pos2  <= leadPos(mag1);
      end
      if (ld3) begin
        sign3 <= sign2;
        zero3 <= zero2;
        exp3  <= EXP_W'(EXP_BIAS) + EXP_W'(pos2);
        frac3 <= {normVal[INT_W-2:0], {PAD_W{1'b0}}};
      end
    end
  end

  assign packedVal = zero3 ? '0 : {sign3, exp3, frac3};

  // R1
  lead_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ld2 && !zero1) |=> (mag2[pos2] && ((mag2 >> pos2) == INT_W'(1))));

  // R4
  zero_pack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ld3 && zero2) |=> (packedVal == '0));
endmodule

// File: rtl/int2dbl_datapath.sv
`timescale 1ns/1ps
module int2dbl_datapath
  import int2dbl_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int LANES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic [LANES*INT_W-1:0]   operand,
  output logic [LANES*DBL_W-1:0]   result
);
  localparam int RES_W = LANES * DBL_W;

  logic [RES_W-1:0] lanePacked;
  logic [RES_W-1:0] resQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    int2dbl_lane #(.INT_W(INT_W)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .ld1      (strobe.s1Load),
      .ld2      (strobe.s2Load),
      .ld3      (strobe.s3Load),
      .src      (operand[g*INT_W +: INT_W]),
      .packedVal(lanePacked[g*DBL_W +: DBL_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ <= '0;
    end else if (strobe.outLoad) begin
      resQ <= strobe.outZero ? '0 : lanePacked;
    end
  end

  assign result = resQ;
endmodule

// File: rtl/int2dbl_ctrl.sv
`timescale 1ns/1ps
module int2dbl_ctrl
  import int2dbl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inEmulate,
  input  logic      inOsSave,
  input  logic      inFeatureOn,
  input  logic      inTaskSwitched,
  output logic      inReady,
  output dpStrobe_t strobe,
  output logic      outValid,
  output fault_e    outFault
);
  localparam int LAST = PIPE_STG - 1;

  logic               readyQ;
  logic [PIPE_STG-1:0] vldQ;
  fault_e             fltQ [PIPE_STG];
  logic               outValidQ;
  fault_e             outFaultQ;

  logic   accept;
  logic   badOp;
  fault_e issueFault;

  always_comb begin
    accept = inValid && readyQ;
    badOp  = inEmulate || !inOsSave || !inFeatureOn;
    if (badOp)               issueFault = FLT_BAD_OP;
    else if (inTaskSwitched) issueFault = FLT_NO_DEV;
    else                     issueFault = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ    <= 1'b0;
      vldQ      <= '0;
      for (int i = 0; i < PIPE_STG; i++) fltQ[i] <= FLT_NONE;
      outValidQ <= 1'b0;
      outFaultQ <= FLT_NONE;
    end else begin
      readyQ  <= 1'b1;
      vldQ    <= {vldQ[PIPE_STG-2:0], accept};
      fltQ[0] <= issueFault;
      for (int i = 1; i < PIPE_STG; i++) fltQ[i] <= fltQ[i-1];
      outValidQ <= vldQ[LAST];
      outFaultQ <= vldQ[LAST] ? fltQ[LAST] : FLT_NONE;
    end
  end

  always_comb begin
    strobe.s1Load  = accept;
    strobe.s2Load  = vldQ[0];
    strobe.s3Load  = vldQ[1];
    strobe.outLoad = vldQ[LAST];
    strobe.outZero = (fltQ[LAST] != FLT_NONE);
  end

  assign inReady  = readyQ;
  assign outValid = outValidQ;
  assign outFault = outFaultQ;

  // R6
  bad_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && badOp) |=> ##3 (outFault == FLT_BAD_OP));

  // R7
  no_dev_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !badOp && inTaskSwitched) |=> ##3 (outFault == FLT_NO_DEV));

  // R8
  fault_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && inEmulate && inTaskSwitched) |=> ##3 (outFault != FLT_NO_DEV));

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> inReady);
endmodule

// File: rtl/int2dbl_unit.sv
`timescale 1ns/1ps
module int2dbl_unit
  import int2dbl_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int LANES  = 2,
  parameter int OPND_W = 128
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [OPND_W-1:0]      inOperand,
  input  logic                   inEmulate,
  input  logic                   inOsSave,
  input  logic                   inFeatureOn,
  input  logic                   inTaskSwitched,
  output logic                   outValid,
  output logic [1:0]             outFault,
  output logic [LANES*DBL_W-1:0] outResult
);
  localparam int SRC_W = LANES * INT_W;

  dpStrobe_t strobe;
  fault_e    faultCode;
  logic      unusedUpper;

  assign unusedUpper = ^inOperand[OPND_W-1:SRC_W];

  int2dbl_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .inEmulate     (inEmulate),
    .inOsSave      (inOsSave),
    .inFeatureOn   (inFeatureOn),
    .inTaskSwitched(inTaskSwitched),
    .inReady       (inReady),
    .strobe        (strobe),
    .outValid      (outValid),
    .outFault      (faultCode)
  );

  int2dbl_datapath #(.INT_W(INT_W), .LANES(LANES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .operand(inOperand[SRC_W-1:0]),
    .result (outResult)
  );

  assign outFault = faultCode;

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> ##3 outValid);

  // R9
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outFault != 2'b00) |-> (outResult == '0));

  // R9
  fault_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outFault != 2'b00) |-> outValid);
endmodule

// File: tb/int2dbl_unit_bench.sv
`timescale 1ns/1ps
module int2dbl_unit_bench;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [127:0] inOperand;
  logic         inEmulate, inOsSave, inFeatureOn, inTaskSwitched;
  logic         outValid;
  logic [1:0]   outFault;
  logic [127:0] outResult;

  always #2.5 clk = ~clk;

  int2dbl_unit u_int2dbl_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOperand(inOperand), .inEmulate(inEmulate), .inOsSave(inOsSave),
    .inFeatureOn(inFeatureOn), .inTaskSwitched(inTaskSwitched),
    .outValid(outValid), .outFault(outFault), .outResult(outResult)
  );

  localparam logic [3:0] CTL_OK = 4'b0110;  // {taskSw, feature, osSave, emulate}

  int           testCount = 0;
  int           failCount = 0;
  int           stepN = 0;
  logic         expV [8];
  logic [1:0]   expF [8];
  logic [127:0] expR [8];
  string        expTag [8];
  logic [31:0]  rr;
  logic [127:0] opv;

  function automatic logic [63:0] refDbl(input logic [31:0] x);
    real r;
    r = $itor($signed(x));
    return $realtobits(r);
  endfunction

  function automatic logic [1:0] refFault(input logic [3:0] ctl);
    if (ctl[0] || !ctl[1] || !ctl[2]) return 2'b01;
    if (ctl[3]) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [127:0] op, input logic [3:0] ctl);
    int slot;
    logic [1:0] f;
    string tag;
    @(negedge clk);
    if (stepN >= 4) begin
      slot = (stepN - 4) % 8;
      if (expV[slot]) begin
        check(outValid == 1'b1, "R10 outValid after four edges", 128'(outValid), 128'(1));
        check(outFault == expF[slot], "R6 R7 R8 fault code", 128'(outFault), 128'(expF[slot]));
        check(outResult == expR[slot], {expTag[slot], " result"}, outResult, expR[slot]);
      end else begin
        check(outValid == 1'b0, "R10 outValid idle", 128'(outValid), 128'(0));
        check(outFault == 2'b00, "R9 fault code idle", 128'(outFault), 128'(0));
      end
    end
    check(inReady == 1'b1, "R10 inReady held", 128'(inReady), 128'(1));
    inValid        = v;
    inOperand      = op;
    inEmulate      = ctl[0];
    inOsSave       = ctl[1];
    inFeatureOn    = ctl[2];
    inTaskSwitched = ctl[3];
    slot = stepN % 8;
    f = refFault(ctl);
    if (f != 2'b00) tag = "R9";
    else if (op[31:0] == '0 || op[63:32] == '0) tag = "R4 R1 R2";
    else if (op[31] || op[63]) tag = "R3 R1 R2";
    else tag = "R1 R2";
    if (op[127:64] != '0) tag = {tag, " R5"};
    expV[slot]   = v;
    expF[slot]   = f;
    expR[slot]   = (f != 2'b00) ? 128'(0) : {refDbl(op[63:32]), refDbl(op[31:0])};
    expTag[slot] = tag;
    stepN++;
  endtask

  initial begin
    logic [31:0] edgeVals [5];
    edgeVals[0] = 32'h0000_0000; edgeVals[1] = 32'h0000_0001;
    edgeVals[2] = 32'hFFFF_FFFF; edgeVals[3] = 32'h7FFF_FFFF;
    edgeVals[4] = 32'h8000_0000;
    for (int i = 0; i < 8; i++) expV[i] = 1'b0;
    rstN = 1'b0; inValid = 1'b0; inOperand = '0;
    inEmulate = 1'b0; inOsSave = 1'b1; inFeatureOn = 1'b1; inTaskSwitched = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(outValid == 1'b0, "R11 outValid in reset", 128'(outValid), 128'(0));
    check(outFault == 2'b00, "R11 outFault in reset", 128'(outFault), 128'(0));
    check(outResult == '0, "R11 outResult in reset", outResult, 128'(0));
    check(inReady == 1'b0, "R11 inReady in reset", 128'(inReady), 128'(0));
    rstN = 1'b1;
    @(posedge clk);
    step(1'b0, '0, CTL_OK);
    // edge values in both lanes (R1 R2 R3 R4), upper half random (R5)
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        step(1'b1, {$urandom, $urandom, edgeVals[b], edgeVals[a]}, CTL_OK);
    // walking bit positions and low-bit masks, positive and negative
    for (int p = 0; p < 32; p++) begin
      rr = 32'd1 << p;
      step(1'b1, {64'd0, -rr, rr}, CTL_OK);
      rr = (p == 31) ? 32'h7FFF_FFFF : ((32'd2 << p) - 32'd1);
      step(1'b1, {64'd0, rr, -rr}, CTL_OK);
    end
    // R5: same low quadword, upper half all zero then all one
    opv = {64'd0, 32'h1234_5678, 32'hEDCB_A988};
    step(1'b1, opv, CTL_OK);
    step(1'b1, {64'hFFFF_FFFF_FFFF_FFFF, opv[63:0]}, CTL_OK);
    // every control combination back to back (R6 R7 R8 R9)
    for (int c = 0; c < 16; c++)
      step(1'b1, {$urandom, $urandom, $urandom, $urandom}, 4'(c));
    for (int c = 15; c >= 0; c--) begin
      step(1'b1, {$urandom, $urandom, $urandom, $urandom}, 4'(c));
      step(1'b1, {$urandom, $urandom, $urandom, $urandom}, CTL_OK);
    end
    // random stream with gaps and occasional faults
    for (int k = 0; k < 3000; k++) begin
      rr = $urandom;
      step(rr[1:0] != 2'b00, {$urandom, $urandom, $urandom, $urandom},
           (rr[4:2] == 3'b000) ? rr[11:8] : CTL_OK);
    end
    repeat (6) step(1'b0, '0, CTL_OK);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog expired: R10 run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule